// File: doc/BRIEF.md
# Four-Channel Staged-Reload Clock Divider

This block derives several per-core clock enables from one parent clock. Each channel counts parent cycles. It raises a one-cycle strobe in the last cycle of every output period. It also drives a divided level that is high for the first half of each period, rounded up. Software programs the ratios through a small synchronous register port.

Ratios do not take effect when they are written. The ratio fields act as a staging copy. A reload moves the staged value of each selected channel into its running divider. A reload needs two things: the channel's select bit in the control register, and a rising edge on the global trigger bit.

A channel that receives a reload waits for the end of its current output period before it switches. So every output period runs wholly at either the old ratio or the new one. Software may then clear the selects and the trigger without touching the running ratios.

The register side uses a two-state trigger machine. In TRG_LOW the stored trigger bit is 0. A control write with bit 24 set moves it to TRG_HIGH and fires a one-cycle reload request for the selected channels. A control write with bit 24 set while in TRG_HIGH stays in TRG_HIGH and fires nothing. A control write with bit 24 clear returns the machine to TRG_LOW.

Each channel runs a two-state machine. CH_RUN counts at the live ratio. A reload request moves it to CH_PEND and captures the new ratio. In CH_PEND, the last cycle of a period with no new request installs the captured ratio and returns to CH_RUN. A new request in CH_PEND replaces the captured ratio and the channel stays in CH_PEND.

Top module: `cdiv_staged_top`

## Requirements
- R1: After reset, every channel divides by 1, so its strobe is high in every cycle, and both registers read as zero.
- R2: The value register sits at address 0xC. Channel n's 6-bit ratio field occupies bits 8n to 8n+5. A read returns the written fields, and all other bits read as zero.
- R3: The control register sits at address 0x0. Bits 20+n are the per-channel reload selects and bit 24 is the trigger. A read returns those stored bits with all other bits zero. Writes to any other address change nothing, and reads of any other address return zero.
- R4: Writing the value register alone leaves every running ratio unchanged.
- R5: A 0-to-1 transition of the trigger bit reloads exactly those channels whose select bit is written as 1 in the same control write. Every other channel keeps its running ratio, even if its field has changed.
- R6: Writing the control register again with the trigger bit still 1 causes no further reload.
- R7: A reloaded channel switches ratio only at the end of an output period. Each output period is exactly the old ratio or the new ratio long.
- R8: Clearing the selects and the trigger leaves the running ratios unchanged.
- R9: A ratio field of 0 divides by 1.
- R10: The strobe is high only in the last cycle of each period. The level is high for the first ceil(ratio/2) cycles of each period and low for the rest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register byte address |
| reg_wr | input | 1 | Write enable, sampled at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| div_ce | output | 4 | Per-channel end-of-period strobe |
| div_lvl | output | 4 | Per-channel divided level |

## Verification
The hardest case to reach from the ports is a reload request that arrives while a channel is already in CH_PEND, in the very cycle its period ends. This needs a slow channel plus two triggers close together, with the trigger bit dropped between them. The random phase writes ratios up to 7, toggles the trigger bit often, and leaves idle gaps of only a few cycles. This makes such collisions frequent. A cycle-by-cycle bench model predicts every strobe and level.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
    parameter int NUM_CH       = 4;
    parameter int RATIO_W      = 6;
    parameter int DATA_W       = 32;
    parameter int ADDR_W       = 4;
    parameter int FIELD_STRIDE = 8;
    parameter int SEL_LSB      = 20;
    parameter int TRIG_BIT     = 24;
    parameter logic [3:0] CTRL_ADDR = 4'h0;
    parameter logic [3:0] VAL_ADDR  = 4'hC;

    typedef enum logic {TRG_LOW, TRG_HIGH} trig_state_e;
    typedef enum logic {CH_RUN, CH_PEND}   ch_state_e;
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
    import cdiv_pkg::*;
#(
    parameter int N_CH = NUM_CH,
    parameter int RW   = RATIO_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    output logic [N_CH-1:0]     req_o,
    output logic [N_CH*RW-1:0]  ratio_o
);
    logic [RW-1:0]    shadow_q [N_CH];
    logic [N_CH-1:0]  sel_q;
    logic [N_CH-1:0]  req_q;
    logic [RW-1:0]    snap_q   [N_CH];
    trig_state_e      trg_q, trg_d;
    logic             wr_ctrl, wr_val, fire;

    assign wr_ctrl = wr && (addr == CTRL_ADDR);
    assign wr_val  = wr && (addr == VAL_ADDR);

    // Trigger state machine: next state
    always_comb begin
        trg_d = trg_q;
        fire  = 1'b0;
        if (wr_ctrl) begin
            unique case (trg_q)
                TRG_LOW: begin
                    if (wdata[TRIG_BIT]) begin
                        trg_d = TRG_HIGH;
                        fire  = 1'b1;
                    end
                end
                TRG_HIGH: begin
                    if (!wdata[TRIG_BIT]) trg_d = TRG_LOW;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) trg_q <= TRG_LOW;
        else        trg_q <= trg_d;
    end

    // Selects and reload request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            req_q <= '0;
        end else begin
            if (wr_ctrl) sel_q <= wdata[SEL_LSB +: N_CH];
            req_q <= fire ? wdata[SEL_LSB +: N_CH] : '0;
        end
    end

    generate
        for (genvar g = 0; g < N_CH; g++) begin : g_field
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    shadow_q[g] <= '0;
                    snap_q[g]   <= '0;
                end else begin
                    if (wr_val) shadow_q[g] <= wdata[g*FIELD_STRIDE +: RW];
                    if (fire)   snap_q[g]   <= shadow_q[g];
                end
            end
            assign ratio_o[g*RW +: RW] = snap_q[g];
        end
    endgenerate

    assign req_o = req_q;

    // Read mux
    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[SEL_LSB +: N_CH] = sel_q;
            rdata[TRIG_BIT]        = (trg_q == TRG_HIGH);
        end else if (addr == VAL_ADDR) begin
            for (int i = 0; i < N_CH; i++) rdata[i*FIELD_STRIDE +: RW] = shadow_q[i];
        end
    end

    // R6: one request per trigger edge
    a_r6_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |=> (req_q == '0));
    // R5: requests only go to channels that were selected
    a_r5_req_subset: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_q & ~sel_q) == '0));
    // R6: a request needs the trigger to be high
    a_r6_req_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_q) |-> (trg_q == TRG_HIGH));
endmodule

// File: rtl/cdiv_channel.sv
module cdiv_channel
    import cdiv_pkg::*;
#(
    parameter int RW = RATIO_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [RW-1:0] ratio_i,
    output logic          ce_o,
    output logic          lvl_o
);
    ch_state_e     st_q, st_d;
    logic [RW-1:0] live_q, live_d;
    logic [RW-1:0] next_q, next_d;
    logic [RW-1:0] cnt_q;
    logic [RW-1:0] req_eff;
    logic [RW:0]   half;
    logic          at_end;

    assign req_eff = (ratio_i == '0) ? RW'(1) : ratio_i;
    assign at_end  = (cnt_q == live_q - RW'(1));
    assign half    = ({1'b0, live_q} + (RW+1)'(1)) >> 1;

    // Next-state logic
    always_comb begin
        st_d   = st_q;
        live_d = live_q;
        next_d = next_q;
        unique case (st_q)
            CH_RUN: begin
                if (req_i) begin
                    st_d   = CH_PEND;
                    next_d = req_eff;
                end
            end
            CH_PEND: begin
                if (req_i) begin
                    next_d = req_eff;
                end else if (at_end) begin
                    live_d = next_q;
                    st_d   = CH_RUN;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_RUN;
            live_q <= RW'(1);
            next_q <= RW'(1);
            cnt_q  <= '0;
        end else begin
            st_q   <= st_d;
            live_q <= live_d;
            next_q <= next_d;
            cnt_q  <= at_end ? '0 : cnt_q + RW'(1);
        end
    end

    // Outputs
    always_comb begin
        ce_o  = at_end;
        lvl_o = ({1'b0, cnt_q} < half);
    end

    // R7: ratio changes only at a period end while pending
    a_r7_land_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q != $past(live_q)) |-> $past(at_end && st_q == CH_PEND));
    // R7: the count never passes the live ratio
    a_r7_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < live_q);
    // R9: the live ratio is never zero
    a_r9_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        live_q != '0);
    // R10: the level rises only at a period start
    a_r10_level_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lvl_o) |-> (cnt_q == '0));
endmodule

// File: rtl/cdiv_staged_top.sv
module cdiv_staged_top
    import cdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [3:0]        div_ce,
    output logic [3:0]        div_lvl
);
    localparam int RTOT = NUM_CH * RATIO_W;

    logic [NUM_CH-1:0] req;
    logic [RTOT-1:0]   ratio;

    cdiv_regs #(.N_CH(NUM_CH), .RW(RATIO_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .req_o   (req),
        .ratio_o (ratio)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            cdiv_channel #(.RW(RATIO_W)) u_ch (
                .clk     (clk),
                .rst_n   (rst_n),
                .req_i   (req[c]),
                .ratio_i (ratio[c*RATIO_W +: RATIO_W]),
                .ce_o    (div_ce[c]),
                .lvl_o   (div_lvl[c])
            );
        end
    endgenerate
endmodule

// File: tb/tb_cdiv_staged_top.sv
`timescale 1ns/1ps
module tb_cdiv_staged_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [3:0]  div_ce, div_lvl;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    cdiv_staged_top dut (.*);

    always #5 clk = ~clk;

    // Reference model of the requirements
    int       m_pos [4];
    int       m_live[4];
    int       m_nxt [4];
    bit       m_pend[4];
    bit [5:0] m_shadow[4];
    int       m_pratio[4];
    bit [3:0] m_sel, m_psel;
    bit       m_trig, m_pulse;

    function automatic int eff(input int r);
        return (r == 0) ? 1 : r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int n = 0; n < 4; n++) begin
                m_pos[n] = 0; m_live[n] = 1; m_nxt[n] = 1; m_pend[n] = 0;
                m_shadow[n] = 0; m_pratio[n] = 0;
            end
            m_sel = 0; m_psel = 0; m_trig = 0; m_pulse = 0;
        end else begin
            for (int n = 0; n < 4; n++) begin
                bit bnd;
                bnd = (m_pos[n] == m_live[n] - 1);
                m_pos[n] = bnd ? 0 : m_pos[n] + 1;
                if (m_pulse && m_psel[n]) begin
                    m_pend[n] = 1; m_nxt[n] = eff(m_pratio[n]);
                end else if (bnd && m_pend[n]) begin
                    m_live[n] = m_nxt[n]; m_pend[n] = 0;
                end
            end
            m_pulse = 0;
            if (reg_wr && reg_addr == 4'h0) begin
                if (reg_wdata[24] && !m_trig) begin
                    m_pulse = 1;
                    m_psel  = reg_wdata[23:20];
                    for (int n = 0; n < 4; n++) m_pratio[n] = m_shadow[n];
                end
                m_sel  = reg_wdata[23:20];
                m_trig = reg_wdata[24];
            end
            if (reg_wr && reg_addr == 4'hC)
                for (int n = 0; n < 4; n++) m_shadow[n] = reg_wdata[8*n +: 6];
        end
    end

    // R7 R10: cycle-by-cycle strobe and level comparison
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int n = 0; n < 4; n++) begin
                bit ece, elv;
                ece = (m_pos[n] == m_live[n] - 1);
                elv = (m_pos[n] < (m_live[n] + 1) / 2);
                checks++;
                if (div_ce[n] !== ece || div_lvl[n] !== elv) begin
                    fails++;
                    $display("FAIL R7 R10 ch%0d ce/lvl actual=%b%b expected=%b%b t=%0t",
                             n, div_ce[n], div_lvl[n], ece, elv, $time);
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a; reg_wr = 0;
        #1 chk(req, reg_rdata, exp);
    endtask

    function automatic logic [31:0] exp_val();
        logic [31:0] v = 0;
        for (int n = 0; n < 4; n++) v[8*n +: 6] = m_shadow[n];
        return v;
    endfunction

    function automatic logic [31:0] exp_ctrl();
        return ({27'b0, m_trig, m_sel} << 20);
    endfunction

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    // Period of channel ch in cycles between two strobes
    task automatic meas(input int ch, output int p);
        p = 0;
        do @(negedge clk); while (!div_ce[ch]);
        do begin @(negedge clk); p++; end while (!div_ce[ch]);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int p, hi;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk("R1 ctrl", 4'h0, 32'h0);
        rd_chk("R1 value", 4'hC, 32'h0);
        #1 chk("R1 strobes", {28'b0, div_ce}, 32'hF);
        // R2 fields masked
        wr(4'hC, 32'hC3C0C3C2);
        rd_chk("R2 value read", 4'hC, 32'h03000302);
        // R4 no effect without trigger
        meas(0, p); chk("R4 ch0 period", p, 1);
        // R5 staged reload of ch0, ch1, ch3
        wr(4'h0, 32'h00B00000);
        wr(4'h0, 32'h01B00000);
        rd_chk("R3 ctrl read", 4'h0, 32'h01B00000);
        idle(8);
        meas(0, p); chk("R5 ch0 period", p, 2);
        meas(1, p); chk("R5 ch1 period", p, 3);
        meas(3, p); chk("R5 ch3 period", p, 3);
        // R10 level high count for ratio 3
        do @(negedge clk); while (!div_ce[1]);
        hi = 0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); hi += div_lvl[1]; end
        chk("R10 ch1 level high cycles", hi, 2);
        // R6 held trigger: rewrite with bit 24 still set
        wr(4'hC, 32'h03000303);
        wr(4'h0, 32'h01B00000);
        idle(8);
        meas(0, p); chk("R6 ch0 period", p, 2);
        // R8 clearing keeps ratios
        wr(4'h0, 32'h0);
        idle(6);
        meas(1, p); chk("R8 ch1 period", p, 3);
        meas(0, p); chk("R8 ch0 period", p, 2);
        // R9 field 0 acts as 1
        wr(4'hC, 32'h03000003);
        wr(4'h0, 32'h00200000);
        wr(4'h0, 32'h01200000);
        idle(8);
        meas(1, p); chk("R9 ch1 period", p, 1);
        // R3 unknown address
        wr(4'h4, 32'hFFFFFFFF);
        rd_chk("R3 other address", 4'h4, 32'h0);
        rd_chk("R3 ctrl unchanged", 4'h0, 32'h01200000);
        rd_chk("R2 value unchanged", 4'hC, 32'h03000003);
        // Random phase
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: wr(4'hC, $urandom & 32'h07070707);
                1: wr(4'h0, {7'b0, 1'($urandom), 4'($urandom), 20'b0});
                2: begin
                    rd_chk("R2 random value read", 4'hC, exp_val());
                    rd_chk("R3 random ctrl read", 4'h0, exp_ctrl());
                end
                default: idle($urandom_range(1, 9));
            endcase
        end
        idle(20);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule